// File: doc/BRIEF.md
# Read-Only Sync Counter Peripheral

This block is a memory-mapped timer that software can only read. It keeps a free-running count that steps once for each pulse of a 32768 Hz tick-enable input. The count starts at zero when reset is released, so a reading is the time since reset in units of 1/32768 s. A small register bus presents an address, an access size, a read strobe and a write strobe. One cycle later the block returns read data and an error flag.

Two registers can be read. One holds a constant revision word and the other gives the live count. A read can fetch either one as a full word or in two 16-bit halves. When software reads the low half of a register, the block copies that register's upper 16 bits into a holding register. A later read of the upper half returns the copy and not the live count, so the two halves always come from the same instant. The bus rejects every write, every byte-sized access and every word read at an unknown offset.

The count width can be set to a value below 32 for small builds; the value is then zero-extended on the bus. The counter is built from equal segments chained by carry enables.

Top module: `synccnt_periph`

## Requirements
- R1: After reset the count is 0, the holding register is 0, and both read data and the error flag are 0 until the first access.
- R2: The count goes up by exactly 1 on each clock cycle in which the tick input is high, holds otherwise, and wraps from its all-ones value to 0. A count narrower than 32 bits is zero-extended on the bus.
- R3: A word read (size 2'b10) at offset 0x00 returns 0x00000021 with the error flag low, one cycle after the read strobe.
- R4: A word read at offset 0x10 returns the count as it stood in the strobe cycle, before any increment from a tick in that same cycle.
- R5: A halfword read (size 2'b01) with address bit 1 clear works as follows:
  - It forms an address by clearing bit 1 and takes that register's word value (0x00 gives the revision word, 0x10 gives the count, any other offset gives 0).
  - It returns bits 15:0 of that word value on data bits 15:0, with data bits 31:16 at zero.
  - In the same access it loads the holding register with bits 31:16 of that word value.
- R6: A halfword read with address bit 1 set returns the holding register on data bits 15:0, with bits 31:16 at zero and the error flag low, whatever the other address bits are. It leaves the holding register unchanged.
- R7: A read of size 2'b00 (byte) or of the reserved size 2'b11 returns data 0 with the error flag high. It leaves the holding register unchanged.
- R8: Any write strobe, at any offset and any size, returns data 0 with the error flag high. It changes neither the count nor the holding register. When both strobes are high, the access is treated as a write.
- R9: A word read at any offset other than 0x00 and 0x10 returns 0 with the error flag high. A halfword low-half read whose cleared address matches neither offset also sets the error flag.
- R10: The error flag is high only in the cycle directly after a strobe. In every cycle that does not follow a strobe, read data and the error flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Single-cycle 32768 Hz count enable, in the bus clock domain |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rdata_o | output | 32 | Response data, valid the cycle after a strobe |
| bus_err_o | output | 1 | Response error, valid the cycle after a strobe |

## Verification
The assertions assume that each strobe lasts one cycle and that the tick input is already synchronous to the bus clock. The response checks also assume that no strobe is high while reset is asserted. The stimulus drives every input on the falling clock edge and holds the strobes low throughout reset. Tick runs are either back to back or kept apart from accesses, except where a tick is deliberately placed in the same cycle as a read to check which count value the read captures. A second, narrow instance exercises the wrap within a short run, because the full 32-bit count cannot reach its limit within the bench's length.

// File: rtl/synccnt_pkg.sv
package synccnt_pkg;

   localparam int DATA_W = 32;
   localparam int HALF_W = DATA_W / 2;

   localparam int OFS_REV = 'h00;
   localparam int OFS_CNT = 'h10;

   localparam logic [DATA_W-1:0] REV_WORD = 32'h0000_0021;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_e;

endpackage

// File: rtl/synccnt_counter.sv
module synccnt_counter #(
   parameter int CNT_W = 32,
   parameter int SEG_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o
);

   localparam int NSEG = CNT_W / SEG_W;

   if (SEG_W < 1 || CNT_W % SEG_W != 0) begin : g_bad_seg
      $error("synccnt_counter: CNT_W must be a multiple of SEG_W");
   end

   logic [NSEG-1:0]            carry;
   logic [NSEG-1:0][SEG_W-1:0] seg_w;

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      logic [SEG_W-1:0] q;

      if (g == 0) begin : g_first
         assign carry[g] = tick_i;
      end else begin : g_next
         assign carry[g] = carry[g-1] & (&seg_w[g-1]);
      end

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            q <= '0;
         end else if (carry[g]) begin
            q <= q + 1'b1;
         end
      end

      assign seg_w[g] = q;
   end

   assign cnt_o = seg_w;

   // R2
   cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i |=> (cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1))));

   // R2
   cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(cnt_o));

endmodule

// File: rtl/synccnt_snap.sv
module synccnt_snap #(
   parameter int HOLD_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ld_i,
   input  logic [HOLD_W-1:0] ld_val_i,
   output logic [HOLD_W-1:0] hold_o
);

   logic [HOLD_W-1:0] hold_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hold_q <= '0;
      end else if (ld_i) begin
         hold_q <= ld_val_i;
      end
   end

   assign hold_o = hold_q;

   // R6
   hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ld_i |=> $stable(hold_q));

   // R5
   hold_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_i |=> (hold_q == $past(ld_val_i)));

endmodule

// File: rtl/synccnt_decode.sv
module synccnt_decode
   import synccnt_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        size_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] cnt_i,
   input  logic [HALF_W-1:0] hold_i,
   output logic              fire_o,
   output logic [DATA_W-1:0] data_o,
   output logic              err_o,
   output logic              ld_o,
   output logic [HALF_W-1:0] ld_val_o
);

   acc_size_e         size;
   logic [ADDR_W-1:0] eff_addr;
   logic              sel_rev;
   logic              sel_cnt;
   logic              bad_reg;
   logic [DATA_W-1:0] word_val;

   assign size = acc_size_e'(size_i);

   always_comb begin
      eff_addr = addr_i;
      if (size == SZ_HALF) begin
         eff_addr[1] = 1'b0;
      end
   end

   assign sel_rev  = (eff_addr == ADDR_W'(OFS_REV));
   assign sel_cnt  = (eff_addr == ADDR_W'(OFS_CNT));
   assign bad_reg  = !(sel_rev || sel_cnt);
   assign word_val = sel_rev ? REV_WORD : (sel_cnt ? cnt_i : '0);
   assign fire_o   = rd_i | wr_i;

   always_comb begin
      data_o   = '0;
      err_o    = 1'b0;
      ld_o     = 1'b0;
      ld_val_o = word_val[DATA_W-1:HALF_W];
      if (wr_i) begin
         err_o = 1'b1;
      end else if (rd_i) begin
         case (size)
            SZ_WORD: begin
               data_o = word_val;
               err_o  = bad_reg;
            end
            SZ_HALF: begin
               if (addr_i[1]) begin
                  data_o = DATA_W'(hold_i);
               end else begin
                  data_o = DATA_W'(word_val[HALF_W-1:0]);
                  err_o  = bad_reg;
                  ld_o   = 1'b1;
               end
            end
            default: begin
               err_o = 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/synccnt_periph.sv
module synccnt_periph
   import synccnt_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int CNT_W  = 32,
   parameter int SEG_W  = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [1:0]        bus_size_i,
   input  logic              bus_rd_i,
   input  logic              bus_wr_i,
   output logic [31:0]       bus_rdata_o,
   output logic              bus_err_o
);

   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("synccnt_periph: CNT_W must lie in 1..32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("synccnt_periph: ADDR_W must reach offset 0x10");
   end

   logic [CNT_W-1:0]  cnt;
   logic [HALF_W-1:0] hold;
   logic              fire;
   logic [DATA_W-1:0] rsp_data;
   logic              rsp_err;
   logic              ld;
   logic [HALF_W-1:0] ld_val;
   logic [DATA_W-1:0] rdata_q;
   logic              err_q;

   synccnt_counter #(.CNT_W(CNT_W), .SEG_W(SEG_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .cnt_o  (cnt)
   );

   synccnt_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr_i   (bus_addr_i),
      .size_i   (bus_size_i),
      .rd_i     (bus_rd_i),
      .wr_i     (bus_wr_i),
      .cnt_i    (DATA_W'(cnt)),
      .hold_i   (hold),
      .fire_o   (fire),
      .data_o   (rsp_data),
      .err_o    (rsp_err),
      .ld_o     (ld),
      .ld_val_o (ld_val)
   );

   synccnt_snap #(.HOLD_W(HALF_W)) u_snap (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (ld),
      .ld_val_i (ld_val),
      .hold_o   (hold)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rdata_q <= '0;
         err_q   <= 1'b0;
      end else begin
         rdata_q <= fire ? rsp_data : '0;
         err_q   <= fire & rsp_err;
      end
   end

   assign bus_rdata_o = rdata_q;
   assign bus_err_o   = err_q;

   // R10
   err_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_err_o |-> $past(bus_rd_i || bus_wr_i));

   // R8
   wr_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_wr_i |=> (bus_err_o && bus_rdata_o == '0));

   // R7
   bad_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_rd_i && !bus_wr_i && (bus_size_i == SZ_BYTE || bus_size_i == SZ_RSVD))
      |=> (bus_err_o && bus_rdata_o == '0));

   // R3
   rev_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_rd_i && !bus_wr_i && bus_size_i == SZ_WORD && bus_addr_i == ADDR_W'(OFS_REV))
      |=> (!bus_err_o && bus_rdata_o == REV_WORD));

   // R6
   upper_half_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_rd_i && !bus_wr_i && bus_size_i == SZ_HALF && bus_addr_i[1])
      |=> (!bus_err_o && bus_rdata_o[31:16] == 16'h0000));

endmodule

// File: tb/synccnt_periph_tb.sv
`timescale 1ns/1ps
module synccnt_periph_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        tick_s = 1'b0;
   logic [11:0] addr = '0;
   logic [1:0]  size = '0;
   logic        rd = 1'b0;
   logic        wr = 1'b0;
   logic [31:0] rdata, rdata_s;
   logic        err, err_s;

   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic [31:0] mcnt = '0;
   logic [15:0] mhold = '0;
   logic [31:0] got_d;
   logic        got_e;

   always #2.5 clk = ~clk;

   synccnt_periph u_dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
      .bus_addr_i(addr), .bus_size_i(size), .bus_rd_i(rd), .bus_wr_i(wr),
      .bus_rdata_o(rdata), .bus_err_o(err)
   );

   synccnt_periph #(.CNT_W(8), .SEG_W(4)) u_dut_small (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_s),
      .bus_addr_i(addr), .bus_size_i(size), .bus_rd_i(rd), .bus_wr_i(wr),
      .bus_rdata_o(rdata_s), .bus_err_o(err_s)
   );

   task automatic chk(string tag, logic [31:0] g, logic [31:0] e);
      n_chk++;
      if (g !== e) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, g, e);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic acc(logic [11:0] a, logic [1:0] s, logic r, logic w, logic tk);
      addr = a; size = s; rd = r; wr = w; tick = tk;
      @(negedge clk);
      got_d = rdata; got_e = err;
      rd = 1'b0; wr = 1'b0; tick = 1'b0; addr = '0; size = '0;
      if (tk) mcnt = mcnt + 1;
   endtask

   task automatic tick_n(int n);
      if (n > 0) begin
         tick = 1'b1;
         repeat (n) @(negedge clk);
         tick = 1'b0;
         mcnt = mcnt + 32'(n);
      end
   endtask

   function automatic logic [31:0] exp_word(logic [11:0] a);
      if (a == 12'h000) return 32'h21;
      if (a == 12'h010) return mcnt;
      return 32'h0;
   endfunction

   function automatic logic exp_bad(logic [11:0] a);
      return !(a == 12'h000 || a == 12'h010);
   endfunction

   task automatic half_sweep(string tag);
      for (int a = 0; a < 32; a += 2) begin
         logic [11:0] ad = 12'(a);
         logic [11:0] base = ad & 12'hFFD;
         logic [31:0] wv = exp_word(base);
         if (ad[1]) begin
            acc(ad, 2'b01, 1'b1, 1'b0, 1'b0);
            chk({tag, " R6 upper data"}, got_d, {16'h0, mhold});
            chk({tag, " R6 upper err"}, {31'h0, got_e}, 32'h0);
         end else begin
            acc(ad, 2'b01, 1'b1, 1'b0, 1'b0);
            chk({tag, " R5 lower data"}, got_d, {16'h0, wv[15:0]});
            chk({tag, " R9 lower err"}, {31'h0, got_e}, {31'h0, exp_bad(base)});
            mhold = wv[31:16];
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rdata idle", rdata, 32'h0);
      chk("R1 err idle", {31'h0, err}, 32'h0);
      acc(12'h010, 2'b10, 1'b1, 1'b0, 1'b0);
      chk("R1 count zero", got_d, 32'h0);
      acc(12'h012, 2'b01, 1'b1, 1'b0, 1'b0);
      chk("R1 holding zero", got_d, 32'h0);

      // R3 revision word
      acc(12'h000, 2'b10, 1'b1, 1'b0, 1'b0);
      chk("R3 rev data", got_d, 32'h21);
      chk("R3 rev err", {31'h0, got_e}, 32'h0);
      @(negedge clk);
      // R10 idle after response
      chk("R10 idle data", rdata, 32'h0);
      chk("R10 idle err", {31'h0, err}, 32'h0);

      // R2 and R4 counting
      tick_n(5);
      acc(12'h010, 2'b10, 1'b1, 1'b0, 1'b0);
      chk("R2 count after 5", got_d, mcnt);
      acc(12'h010, 2'b10, 1'b1, 1'b0, 1'b1);
      chk("R4 read with tick", got_d, 32'd5);
      acc(12'h010, 2'b10, 1'b1, 1'b0, 1'b0);
      chk("R4 read after tick", got_d, 32'd6);
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
      mcnt = mcnt + 2;
      acc(12'h010, 2'b10, 1'b1, 1'b0, 1'b0);
      chk("R2 sparse ticks", got_d, 32'd8);

      // R9 word offset sweep
      for (int a = 0; a < 64; a++) begin
         acc(12'(a), 2'b10, 1'b1, 1'b0, 1'b0);
         chk("R9 word sweep data", got_d, exp_word(12'(a)));
         chk("R9 word sweep err", {31'h0, got_e}, {31'h0, exp_bad(12'(a))});
      end

      half_sweep("small");

      // R7 bad widths
      acc(12'h010, 2'b01, 1'b1, 1'b0, 1'b0);
      mhold = mcnt[31:16];
      for (int a = 0; a < 20; a++) begin
         acc(12'(a), 2'b00, 1'b1, 1'b0, 1'b0);
         chk("R7 byte data", got_d, 32'h0);
         chk("R7 byte err", {31'h0, got_e}, 32'h1);
      end
      acc(12'h010, 2'b11, 1'b1, 1'b0, 1'b0);
      chk("R7 reserved err", {31'h0, got_e}, 32'h1);
      chk("R7 reserved data", got_d, 32'h0);
      acc(12'h012, 2'b01, 1'b1, 1'b0, 1'b0);
      chk("R7 holding kept", got_d, {16'h0, mhold});

      // R8 writes
      for (int s = 0; s < 4; s++) begin
         for (int a = 0; a < 32; a += 2) begin
            acc(12'(a), 2'(s), 1'b0, 1'b1, 1'b0);
            chk("R8 write data", got_d, 32'h0);
            chk("R8 write err", {31'h0, got_e}, 32'h1);
         end
      end
      acc(12'h010, 2'b01, 1'b1, 1'b1, 1'b0);
      chk("R8 read+write err", {31'h0, got_e}, 32'h1);
      chk("R8 read+write data", got_d, 32'h0);
      acc(12'h012, 2'b01, 1'b1, 1'b0, 1'b0);
      chk("R8 holding kept", got_d, {16'h0, mhold});
      acc(12'h010, 2'b10, 1'b1, 1'b0, 1'b0);
      chk("R8 count kept", got_d, mcnt);

      // R2 wrap on narrow instance
      tick_s = 1'b1;
      repeat (259) @(negedge clk);
      tick_s = 1'b0;
      acc(12'h010, 2'b10, 1'b1, 1'b0, 1'b0);
      chk("R2 narrow wrap", rdata_s, 32'd3);
      chk("R2 wide unaffected", got_d, mcnt);

      // R5 and R6 snapshot across a carry into the upper half
      tick_n(32'h0000_FFFF - mcnt);
      acc(12'h010, 2'b01, 1'b1, 1'b0, 1'b1);
      chk("R5 low at FFFF", got_d, 32'h0000_FFFF);
      mhold = 16'h0000;
      acc(12'h010, 2'b10, 1'b1, 1'b0, 1'b0);
      chk("R4 live after carry", got_d, 32'h0001_0000);
      acc(12'h012, 2'b01, 1'b1, 1'b0, 1'b0);
      chk("R6 snapshot not live", got_d, 32'h0);
      tick_n(4);
      acc(12'h010, 2'b01, 1'b1, 1'b0, 1'b0);
      chk("R5 low after carry", got_d, 32'h0000_0004);
      mhold = 16'h0001;
      tick_n(3);
      acc(12'h012, 2'b01, 1'b1, 1'b0, 1'b0);
      chk("R6 upper via 0x12", got_d, 32'h1);
      acc(12'h006, 2'b01, 1'b1, 1'b0, 1'b0);
      chk("R6 upper via 0x06", got_d, 32'h1);
      acc(12'h000, 2'b01, 1'b1, 1'b0, 1'b0);
      chk("R5 low of rev", got_d, 32'h21);
      mhold = 16'h0000;
      acc(12'h002, 2'b01, 1'b1, 1'b0, 1'b0);
      chk("R5 rev upper zero", got_d, 32'h0);
      half_sweep("large");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule